// File: doc/BRIEF.md
# RS485 Driver Enable Sequencer

This block drives the transmit-enable line of a half-duplex RS485 transceiver around serial transmissions. While the half-duplex mode is on, the output that would otherwise serve as request-to-send carries the driver enable. When the framer reports data waiting, the sequencer turns the driver on first. It then lets a programmed number of timing ticks pass before it allows the framer to begin its start bit. When the framer reports both its holding stage and its shift stage empty, the driver stays on for a second programmed number of ticks. After that the line is released.

The framer waits for `start_ok` before it begins a character. The tick input is a one-cycle strobe from any baud or sub-baud divider, and both intervals are counted in those strobes. When the mode is off, the driver enable stays low and the framer is always free to start, so the block is transparent to ordinary full-duplex use.

Top module: `rs485_de_seq`

## Requirements
- R1: While `mode_en` is 0, `drv_en` is 0 and `start_ok` is 1 in every cycle.
- R2: With `mode_en` 1 and a nonzero setup count, `tx_pending` seen in the idle state raises `drv_en` at the next clock edge while `start_ok` stays 0.
- R3: After the driver turns on, `start_ok` rises at the clock edge that samples the setup-count-th tick pulse. Cycles without `tick` do not advance the count.
- R4: A setup count of 0 raises `drv_en` and `start_ok` together at the edge after `tx_pending` is seen.
- R5: Once granted, `start_ok` and `drv_en` stay 1 until an edge samples `tx_idle` 1 with `tx_pending` 0.
- R6: In the hold phase `drv_en` stays 1 with `start_ok` 0, and `drv_en` falls at the edge that samples the hold-count-th tick.
- R7: A hold count of 0 drops `drv_en` at the edge that samples `tx_idle` 1 with `tx_pending` 0.
- R8: `tx_pending` seen during the hold phase returns the block to the granted state at the next edge, with `drv_en` never going low.
- R9: During reset the sequencer is idle: `drv_en` is 0 and `start_ok` equals the inverse of `mode_en`.
- R10: Clearing `mode_en` drops `drv_en` in the same cycle, and the sequencer is idle afterwards. A later enable without pending data leaves `drv_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 1 | Half-duplex driver sequencing on |
| setup_cnt | input | 12 | Ticks from driver on to start grant |
| hold_cnt | input | 12 | Ticks from transmitter empty to driver off |
| tx_pending | input | 1 | Framer has data waiting to send |
| tx_idle | input | 1 | Holding and shift stages both empty |
| tick | input | 1 | One-cycle timing strobe |
| drv_en | output | 1 | Transceiver driver enable (request-to-send pin) |
| start_ok | output | 1 | Framer may start a character |

## Verification
Directed sequences cover each phase transition. Setup intervals with and without ticks separate counting of strobes from counting of cycles. A zero and a nonzero count in each phase separate the bypass path from the timed path. A pending pulse in the middle of a hold shows whether the driver re-arms without a glitch. Long random runs then vary the tick density, pending and empty patterns, counts from 0 to 4 and mode toggles, and compare both outputs in every cycle against a phase model in the bench. This catches off-by-one interval errors and wrong transition priority.

// File: rtl/rs485_pkg.sv
package rs485_pkg;

    localparam int CNT_W = 12;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_SETUP  = 2'd1,
        SQ_ACTIVE = 2'd2,
        SQ_HOLD   = 2'd3
    } sq_state_e;

    typedef struct packed {
        logic             load;
        logic [CNT_W-1:0] value;
    } tmr_cmd_t;

    function automatic logic cnt_is_zero(input logic [CNT_W-1:0] v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/rs485_tick_timer.sv
module rs485_tick_timer #(
    parameter int W = rs485_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (tick && (remain != '0)) begin
            remain <= remain - ONE;
        end
    end

    // the strobe that consumes the last remaining tick
    assign expire = tick && (remain == ONE);

endmodule

// File: rtl/rs485_de_fsm.sv
module rs485_de_fsm
    import rs485_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_en,
    input  logic [CNT_W-1:0] setup_cnt,
    input  logic [CNT_W-1:0] hold_cnt,
    input  logic             tx_pending,
    input  logic             tx_idle,
    input  logic             expire,
    output tmr_cmd_t         tmr_cmd,
    output sq_state_e        state
);
    sq_state_e nxt;

    always_comb begin
        nxt     = state;
        tmr_cmd = '{load: 1'b0, value: '0};
        unique case (state)
            SQ_IDLE: begin
                if (tx_pending) begin
                    if (cnt_is_zero(setup_cnt)) begin
                        nxt = SQ_ACTIVE;
                    end else begin
                        nxt     = SQ_SETUP;
                        tmr_cmd = '{load: 1'b1, value: setup_cnt};
                    end
                end
            end
            SQ_SETUP: begin
                if (expire) nxt = SQ_ACTIVE;
            end
            SQ_ACTIVE: begin
                if (tx_idle && !tx_pending) begin
                    if (cnt_is_zero(hold_cnt)) begin
                        nxt = SQ_IDLE;
                    end else begin
                        nxt     = SQ_HOLD;
                        tmr_cmd = '{load: 1'b1, value: hold_cnt};
                    end
                end
            end
            SQ_HOLD: begin
                if (tx_pending)  nxt = SQ_ACTIVE;
                else if (expire) nxt = SQ_IDLE;
            end
            default: nxt = SQ_IDLE;
        endcase
        if (!mode_en) begin
            nxt     = SQ_IDLE;
            tmr_cmd = '{load: 1'b0, value: '0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/rs485_de_seq.sv
module rs485_de_seq
    import rs485_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_en,
    input  logic [CNT_W-1:0] setup_cnt,
    input  logic [CNT_W-1:0] hold_cnt,
    input  logic             tx_pending,
    input  logic             tx_idle,
    input  logic             tick,
    output logic             drv_en,
    output logic             start_ok
);
    sq_state_e state;
    tmr_cmd_t  tmr_cmd;
    logic      expire;

    rs485_de_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_en    (mode_en),
        .setup_cnt  (setup_cnt),
        .hold_cnt   (hold_cnt),
        .tx_pending (tx_pending),
        .tx_idle    (tx_idle),
        .expire     (expire),
        .tmr_cmd    (tmr_cmd),
        .state      (state)
    );

    rs485_tick_timer #(.W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_cmd.load),
        .load_val (tmr_cmd.value),
        .tick     (tick),
        .expire   (expire)
    );

    assign drv_en   = mode_en && (state != SQ_IDLE);
    assign start_ok = !mode_en || (state == SQ_ACTIVE);

endmodule

// File: rtl/rs485_de_seq_chk.sv
module rs485_de_seq_chk (
    input logic clk,
    input logic rst,
    input logic mode_en,
    input logic tx_pending,
    input logic tx_idle,
    input logic drv_en,
    input logic start_ok
);
    a_r1_mode_off: assert property (@(posedge clk) disable iff (rst)
        !mode_en |-> (!drv_en && start_ok));

    a_r2_grant_needs_driver: assert property (@(posedge clk) disable iff (rst)
        (mode_en && start_ok) |-> drv_en);

    a_r2_rise_needs_pending: assert property (@(posedge clk) disable iff (rst)
        (mode_en && !drv_en && !tx_pending) |=> !drv_en);

    a_r5_grant_held: assert property (@(posedge clk) disable iff (rst)
        (mode_en && start_ok && !tx_idle) |=> (start_ok || !mode_en));

    a_r8_no_drop_when_pending: assert property (@(posedge clk) disable iff (rst)
        (mode_en && drv_en && tx_pending) |=> (drv_en || !mode_en));

    a_r9_reset_idle: assert property (@(posedge clk)
        rst |-> !drv_en);
endmodule

bind rs485_de_seq rs485_de_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_en    (mode_en),
    .tx_pending (tx_pending),
    .tx_idle    (tx_idle),
    .drv_en     (drv_en),
    .start_ok   (start_ok)
);

// File: tb/rs485_de_seq_tb.sv
`timescale 1ns/1ps
module rs485_de_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_en = 1'b0;
    logic [11:0] setup_cnt = '0;
    logic [11:0] hold_cnt = '0;
    logic        tx_pending = 1'b0;
    logic        tx_idle = 1'b1;
    logic        tick = 1'b0;
    logic        drv_en, start_ok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit cmp_on = 1'b0;

    always #2.5 clk = ~clk;

    rs485_de_seq u_dut (
        .clk(clk), .rst(rst), .mode_en(mode_en), .setup_cnt(setup_cnt),
        .hold_cnt(hold_cnt), .tx_pending(tx_pending), .tx_idle(tx_idle),
        .tick(tick), .drv_en(drv_en), .start_ok(start_ok)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // phase model: 0 idle, 1 setup, 2 granted, 3 hold
    int m_phase = 0;
    int m_seen = 0;

    always @(posedge clk) begin
        if (rst || !mode_en) begin
            m_phase <= 0; m_seen <= 0;
        end else begin
            case (m_phase)
                0: if (tx_pending) begin
                       m_phase <= (setup_cnt == 0) ? 2 : 1; m_seen <= 0;
                   end
                1: if (tick) begin
                       if (m_seen + 1 >= int'(setup_cnt)) m_phase <= 2;
                       else m_seen <= m_seen + 1;
                   end
                2: if (tx_idle && !tx_pending) begin
                       m_phase <= (hold_cnt == 0) ? 0 : 3; m_seen <= 0;
                   end
                default: if (tx_pending) m_phase <= 2;
                   else if (tick) begin
                       if (m_seen + 1 >= int'(hold_cnt)) m_phase <= 0;
                       else m_seen <= m_seen + 1;
                   end
            endcase
        end
    end

    function automatic logic exp_drv();
        return mode_en && (m_phase != 0);
    endfunction
    function automatic logic exp_ok();
        return !mode_en || (m_phase == 2);
    endfunction
    function automatic string phase_tag();
        if (!mode_en) return "R1";
        case (m_phase)
            1: return "R3";
            2: return "R5";
            3: return "R6";
            default: return "R2";
        endcase
    endfunction

    always @(posedge clk) begin
        #1;
        if (cmp_on && !rst) begin
            check(phase_tag(), drv_en, exp_drv(), "drv_en vs model");
            check(phase_tag(), start_ok, exp_ok(), "start_ok vs model");
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        // R9: reset with mode off then on
        step();
        check("R9", drv_en, 1'b0, "drv_en in reset, mode off");
        check("R9", start_ok, 1'b1, "start_ok in reset, mode off");
        mode_en = 1'b1; tx_pending = 1'b1;
        step();
        check("R9", drv_en, 1'b0, "drv_en in reset, mode on");
        check("R9", start_ok, 1'b0, "start_ok in reset, mode on");
        tx_pending = 1'b0;
        rst = 1'b0;
        step();
        cmp_on = 1'b1;

        // R4 / R7: zero counts
        tx_idle = 1'b0; tx_pending = 1'b1;
        step();
        check("R4", drv_en, 1'b1, "drv_en with zero setup");
        check("R4", start_ok, 1'b1, "start_ok with zero setup");
        tx_pending = 1'b0; tx_idle = 1'b1;
        step();
        check("R7", drv_en, 1'b0, "drv_en with zero hold");

        // R2 / R3: setup of 3 ticks
        setup_cnt = 12'd3; hold_cnt = 12'd2; tx_idle = 1'b0; tx_pending = 1'b1;
        step();
        check("R2", drv_en, 1'b1, "drv_en after pending");
        check("R2", start_ok, 1'b0, "start_ok held off");
        for (int i = 0; i < 5; i++) step();
        check("R3", start_ok, 1'b0, "no ticks, no grant");
        tick = 1'b1;
        step(); step();
        check("R3", start_ok, 1'b0, "grant after two of three ticks");
        step();
        check("R3", start_ok, 1'b1, "grant after third tick");
        tick = 1'b0;

        // R6 / R8: hold of 2 ticks with re-arm
        tx_pending = 1'b0; tx_idle = 1'b1;
        step();
        check("R6", drv_en, 1'b1, "drv_en in hold");
        check("R6", start_ok, 1'b0, "start_ok in hold");
        tx_pending = 1'b1;
        step();
        check("R8", drv_en, 1'b1, "drv_en after re-arm");
        check("R8", start_ok, 1'b1, "start_ok after re-arm");
        tx_pending = 1'b0;
        step();
        tick = 1'b1;
        step();
        check("R6", drv_en, 1'b1, "drv_en after first hold tick");
        step();
        check("R6", drv_en, 1'b0, "drv_en after second hold tick");
        tick = 1'b0;

        // R10: mode cleared mid transfer
        setup_cnt = 12'd0; tx_idle = 1'b0; tx_pending = 1'b1;
        step();
        check("R10", drv_en, 1'b1, "drv_en before disable");
        mode_en = 1'b0;
        #1;
        check("R10", drv_en, 1'b0, "drv_en same cycle as disable");
        check("R10", start_ok, 1'b1, "start_ok same cycle as disable");
        @(negedge clk);
        step();
        tx_pending = 1'b0;
        mode_en = 1'b1;
        #1;
        check("R10", drv_en, 1'b0, "idle after re-enable");
        @(negedge clk);

        // random phase
        for (int ep = 0; ep < 40; ep++) begin
            mode_en = 1'b0; tx_pending = 1'b0;
            step(); step();
            setup_cnt = 12'($urandom_range(0, 4));
            hold_cnt  = 12'($urandom_range(0, 4));
            mode_en = 1'b1;
            for (int c = 0; c < 300; c++) begin
                tick       = ($urandom_range(0, 2) == 0);
                tx_pending = ($urandom_range(0, 4) == 0);
                tx_idle    = ($urandom_range(0, 1) == 0);
                if ($urandom_range(0, 199) == 0) mode_en = ~mode_en;
                step();
            end
        end

        cmp_on = 1'b0;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule